// File: doc/BRIEF.md
# Bus-Master DMA Register Window Decoder

This block sits behind a 16-byte I/O window that carries the bus-master DMA control registers of two disk channels. Each channel owns an eight-byte slot: channel 0 at offset 0, channel 1 at offset 8. The low four bytes of a slot are decoded here. The high four bytes hold the descriptor-table address, and accesses to them are passed unchanged to an external address-register port.

Within the decoded quad the block keeps two registers per channel. The command register holds the start and direction controls that drive the transfer engine. The status register mixes three kinds of bits: a live view of the engine's active flag, error and interrupt flags that are cleared by writing one, and two plain storage bits. The other two bytes of the quad are windows onto configuration space. One is a restricted alias of the shared mode byte, which carries per-channel interrupt pending and interrupt block bits. The other is a per-channel timing byte. For both, the block only reads the configuration value in and drives write strobes out; configuration space itself is outside the block.

Top module: `dma_regwin`

## Requirements
- R1: After reset, both command registers read 0x00, and both status registers read 0x00 except bit 0, which shows the channel's active input.
- R2: An access to a register byte (slot offsets 0..3) with size code 1 (two bytes) reads 0x0000FFFF. Size code 2 or 3 reads 0xFFFFFFFF. A write of any of these sizes changes no register and raises no configuration strobe.
- R3: For byte accesses (size code 0) to slot offsets 0..3, address bit 3 selects the channel and address bits 1:0 select the register: 0 command, 1 mode alias, 2 status, 3 timing. Byte reads return zero above bit 7.
- R4: Status bits 5 and 6 take the written value on a status write and hold it otherwise.
- R5: Status bits 1 and 2 clear when a status write carries a one in that position, and keep their value when it carries a zero.
- R6: An error event input sets status bit 1 and an interrupt event input sets status bit 2 in the following cycle. A set event wins over a same-cycle clear.
- R7: Status bit 0 always reads the channel's engine-active input, and writes do not affect it. Status bits 3, 4 and 7 read zero.
- R8: A command write stores bit 0 (start, on dma_start) and bit 3 (direction, on dma_dir). All other command bits read zero.
- R9: A mode-alias read returns the full configuration mode byte. A mode-alias write raises cfg_mode_wr for that cycle with cfg_mode_wdata equal to the current mode byte with bits 5:4 replaced by the written bits 5:4, so pending bits 3:2 and bits 7:6 and 1:0 are kept.
- R10: The timing byte reads the channel's own configuration timing byte (cfg_tim_in byte c for channel c). A write raises cfg_tim_wr bit c and places the data on cfg_tim_wdata.
- R11: Any access to slot offsets 4..7, of any size, raises fwd_valid with write flag, channel, offset bits 1:0, size and write data unchanged, and a read returns fwd_rdata. No local register or configuration strobe is affected.
- R12: Reads have no side effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_size | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational, zero when no read |
| eng_active | input | 2 | Engine active flag per channel |
| eng_err_set | input | 2 | Error event per channel |
| eng_irq_set | input | 2 | Interrupt event per channel |
| dma_start | output | 2 | Start control per channel |
| dma_dir | output | 2 | Direction control per channel |
| cfg_mode_in | input | 8 | Shared mode byte from configuration space |
| cfg_mode_wr | output | 1 | Mode byte write strobe |
| cfg_mode_wdata | output | 8 | Merged mode byte to store |
| cfg_tim_in | input | 16 | Timing bytes, byte c for channel c |
| cfg_tim_wr | output | 2 | Timing byte write strobe per channel |
| cfg_tim_wdata | output | 8 | Timing byte write data |
| fwd_valid | output | 1 | Address-register access forwarded |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_chan | output | 1 | Forwarded channel |
| fwd_off | output | 2 | Forwarded byte offset within the address register |
| fwd_size | output | 2 | Forwarded size code |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_rdata | input | 32 | Read data from the address register |

## Verification
The bench builds the block with its defaults: two channels and a 32-bit data path. With these values the channel bit sits at address bit 3, so one run covers both slots, the per-channel timing byte selection and the mirrored status behaviour. A reference model in the bench acts as configuration space, so the merged mode byte and the timing strobes can be checked against their effects. A randomised phase mixes event pulses with same-cycle status writes, which makes the set-over-clear priority and the read-only active bit show up under many data patterns.

// File: rtl/dma_regwin_pkg.sv
package dma_regwin_pkg;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_TIM  = 2'd3
    } reg_sel_e;

    localparam logic [7:0] CMD_KEEP  = 8'h09;
    localparam logic [7:0] STAT_RW   = 8'h60;
    localparam logic [7:0] STAT_W1C  = 8'h06;
    localparam logic [7:0] MODE_BLK  = 8'h30;
    localparam int         ERR_BIT   = 1;
    localparam int         IRQ_BIT   = 2;
    localparam int         START_BIT = 0;
    localparam int         DIR_BIT   = 3;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] stat;
    } chan_regs_t;

endpackage

// File: rtl/dma_regwin_dec.sv
module dma_regwin_dec
    import dma_regwin_pkg::*;
#(
    parameter int CH_BITS = 1,
    parameter int ADDR_W  = CH_BITS + 3
) (
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [1:0]         acc_size,
    output logic               reg_hit,
    output logic               wide_hit,
    output logic               fwd_hit,
    output logic [CH_BITS-1:0] chan,
    output reg_sel_e           sel
);

    logic upper_half;

    always_comb begin
        upper_half = acc_addr[2];
        chan       = acc_addr[ADDR_W-1:3];
        sel        = reg_sel_e'(acc_addr[1:0]);
        fwd_hit    = acc_valid && upper_half;
        reg_hit    = acc_valid && !upper_half && (acc_size == 2'd0);
        wide_hit   = acc_valid && !upper_half && (acc_size != 2'd0);
    end

endmodule

// File: rtl/dma_regwin_chan.sv
module dma_regwin_chan
    import dma_regwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_cmd,
    input  logic       wr_stat,
    input  logic [7:0] wdata,
    input  logic       active,
    input  logic       err_set,
    input  logic       irq_set,
    output logic [7:0] cmd_rd,
    output logic [7:0] stat_rd,
    output logic       start,
    output logic       dir
);

    chan_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_cmd) begin
            regs_d.cmd = wdata & CMD_KEEP;
        end
        if (wr_stat) begin
            regs_d.stat = (wdata & STAT_RW) | (regs_q.stat & ~wdata & STAT_W1C);
        end
        if (err_set) begin
            regs_d.stat[ERR_BIT] = 1'b1;
        end
        if (irq_set) begin
            regs_d.stat[IRQ_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cmd_rd  = regs_q.cmd;
    assign stat_rd = {regs_q.stat[7:1], active};
    assign start   = regs_q.cmd[START_BIT];
    assign dir     = regs_q.cmd[DIR_BIT];

    // R4: storage bits move only on a status write
    a_r4_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> $stable(stat_rd[6:5]));

    // R5: a one written to the error bit clears it unless an event arrives
    a_r5_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[ERR_BIT] && !err_set) |=> !stat_rd[ERR_BIT]);

    // R6: events set their flag, regardless of a concurrent clear
    a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> stat_rd[ERR_BIT]);

    a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> stat_rd[IRQ_BIT]);

    // R8: command register changes only on a command write
    a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cmd |=> $stable(cmd_rd));

endmodule

// File: rtl/dma_regwin.sv
module dma_regwin
    import dma_regwin_pkg::*;
#(
    parameter int NCHAN  = 2,
    parameter int DATA_W = 32,
    localparam int CH_BITS = $clog2(NCHAN),
    localparam int ADDR_W  = CH_BITS + 3,
    localparam int NBYTES  = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [1:0]            acc_size,
    input  logic [DATA_W-1:0]     acc_wdata,
    output logic [DATA_W-1:0]     acc_rdata,
    input  logic [NCHAN-1:0]      eng_active,
    input  logic [NCHAN-1:0]      eng_err_set,
    input  logic [NCHAN-1:0]      eng_irq_set,
    output logic [NCHAN-1:0]      dma_start,
    output logic [NCHAN-1:0]      dma_dir,
    input  logic [7:0]            cfg_mode_in,
    output logic                  cfg_mode_wr,
    output logic [7:0]            cfg_mode_wdata,
    input  logic [NCHAN*8-1:0]    cfg_tim_in,
    output logic [NCHAN-1:0]      cfg_tim_wr,
    output logic [7:0]            cfg_tim_wdata,
    output logic                  fwd_valid,
    output logic                  fwd_write,
    output logic [CH_BITS-1:0]    fwd_chan,
    output logic [1:0]            fwd_off,
    output logic [1:0]            fwd_size,
    output logic [DATA_W-1:0]     fwd_wdata,
    input  logic [DATA_W-1:0]     fwd_rdata
);

    logic               reg_hit, wide_hit, fwd_hit;
    logic [CH_BITS-1:0] chan;
    reg_sel_e           sel;

    logic [NCHAN-1:0]   wr_cmd, wr_stat;
    logic [7:0]         cmd_rd  [NCHAN];
    logic [7:0]         stat_rd [NCHAN];
    logic [7:0]         byte_rd;
    logic               reg_wr;

    dma_regwin_dec #(
        .CH_BITS (CH_BITS),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .reg_hit   (reg_hit),
        .wide_hit  (wide_hit),
        .fwd_hit   (fwd_hit),
        .chan      (chan),
        .sel       (sel)
    );

    assign reg_wr = reg_hit && acc_write;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        assign wr_cmd[c]  = reg_wr && (chan == c) && (sel == SEL_CMD);
        assign wr_stat[c] = reg_wr && (chan == c) && (sel == SEL_STAT);

        dma_regwin_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cmd  (wr_cmd[c]),
            .wr_stat (wr_stat[c]),
            .wdata   (acc_wdata[7:0]),
            .active  (eng_active[c]),
            .err_set (eng_err_set[c]),
            .irq_set (eng_irq_set[c]),
            .cmd_rd  (cmd_rd[c]),
            .stat_rd (stat_rd[c]),
            .start   (dma_start[c]),
            .dir     (dma_dir[c])
        );

        assign cfg_tim_wr[c] = reg_wr && (chan == c) && (sel == SEL_TIM);
    end

    // configuration-space strobes
    always_comb begin
        cfg_mode_wr    = reg_wr && (sel == SEL_MODE);
        cfg_mode_wdata = cfg_mode_wr
                       ? ((cfg_mode_in & ~MODE_BLK) | (acc_wdata[7:0] & MODE_BLK))
                       : 8'h00;
        cfg_tim_wdata  = (|cfg_tim_wr) ? acc_wdata[7:0] : 8'h00;
    end

    // address-register forwarding
    always_comb begin
        fwd_valid = fwd_hit;
        fwd_write = fwd_hit && acc_write;
        fwd_chan  = fwd_hit ? chan : '0;
        fwd_off   = fwd_hit ? acc_addr[1:0] : 2'b00;
        fwd_size  = fwd_hit ? acc_size : 2'b00;
        fwd_wdata = fwd_hit ? acc_wdata : '0;
    end

    // read path
    always_comb begin
        unique case (sel)
            SEL_CMD:  byte_rd = cmd_rd[chan];
            SEL_MODE: byte_rd = cfg_mode_in;
            SEL_STAT: byte_rd = stat_rd[chan];
            default:  byte_rd = cfg_tim_in[chan*8 +: 8];
        endcase

        acc_rdata = '0;
        if (acc_valid && !acc_write) begin
            if (fwd_hit) begin
                acc_rdata = fwd_rdata;
            end else if (wide_hit) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (acc_size == 2'd1) begin
                        if (b < 2) acc_rdata[b*8 +: 8] = 8'hFF;
                    end else begin
                        acc_rdata[b*8 +: 8] = 8'hFF;
                    end
                end
            end else begin
                acc_rdata[7:0] = byte_rd;
            end
        end
    end

    // R2: a wide access to a register byte raises no configuration strobe
    a_r2_wide_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_addr[2] && acc_size != 2'd0) |-> (!cfg_mode_wr && cfg_tim_wr == '0));

    // R9: the merged mode byte keeps every bit outside the block field
    a_r9_mode_keep: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode_wr |-> ((cfg_mode_wdata & ~MODE_BLK) == (cfg_mode_in & ~MODE_BLK)));

    // R11: forwarding and configuration strobes never coincide
    a_r11_fwd_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, cfg_mode_wr, |cfg_tim_wr}));

    // R12: a read raises no write strobe
    a_r12_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |-> (!cfg_mode_wr && cfg_tim_wr == '0 && !fwd_write));

endmodule

// File: tb/dma_regwin_test.sv
module dma_regwin_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [1:0]  eng_active = '0, eng_err_set = '0, eng_irq_set = '0;
    logic [1:0]  dma_start, dma_dir;
    logic [7:0]  cfg_mode = 8'h00;
    logic        cfg_mode_wr;
    logic [7:0]  cfg_mode_wdata;
    logic [7:0]  cfg_tim [2];
    logic [15:0] cfg_tim_in;
    logic [1:0]  cfg_tim_wr;
    logic [7:0]  cfg_tim_wdata;
    logic        fwd_valid, fwd_write;
    logic [0:0]  fwd_chan;
    logic [1:0]  fwd_off, fwd_size;
    logic [31:0] fwd_wdata;
    logic [31:0] fwd_rdata = '0;

    int checks = 0;
    int fails  = 0;

    logic [7:0] ref_cmd  [2];
    logic [7:0] ref_stat [2];

    assign cfg_tim_in = {cfg_tim[1], cfg_tim[0]};

    always #4 clk = ~clk;

    dma_regwin uut (
        .clk (clk), .rst_n (rst_n),
        .acc_valid (acc_valid), .acc_write (acc_write), .acc_addr (acc_addr),
        .acc_size (acc_size), .acc_wdata (acc_wdata), .acc_rdata (acc_rdata),
        .eng_active (eng_active), .eng_err_set (eng_err_set), .eng_irq_set (eng_irq_set),
        .dma_start (dma_start), .dma_dir (dma_dir),
        .cfg_mode_in (cfg_mode), .cfg_mode_wr (cfg_mode_wr), .cfg_mode_wdata (cfg_mode_wdata),
        .cfg_tim_in (cfg_tim_in), .cfg_tim_wr (cfg_tim_wr), .cfg_tim_wdata (cfg_tim_wdata),
        .fwd_valid (fwd_valid), .fwd_write (fwd_write), .fwd_chan (fwd_chan),
        .fwd_off (fwd_off), .fwd_size (fwd_size), .fwd_wdata (fwd_wdata), .fwd_rdata (fwd_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare just after, update model after posedge
    task automatic cycle(input logic v, input logic w, input logic [3:0] a, input logic [1:0] s,
                         input logic [31:0] wd, input logic [1:0] act, input logic [1:0] err,
                         input logic [1:0] irq);
        int          ch;
        logic        fw, byte_reg;
        logic [1:0]  rg;
        logic [31:0] exp_rd;
        logic [1:0]  exp_tw;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = wd;
        eng_active = act; eng_err_set = err; eng_irq_set = irq;
        fwd_rdata = {16'hBEEF, 12'h000, a};
        #1;
        ch = int'(a[3]);
        rg = a[1:0];
        fw = v && a[2];
        byte_reg = v && !a[2] && (s == 2'd0);
        exp_rd = 32'h0;
        if (v && !w) begin
            if (fw) exp_rd = fwd_rdata;
            else if (s == 2'd1) exp_rd = 32'h0000FFFF;
            else if (s != 2'd0) exp_rd = 32'hFFFFFFFF;
            else case (rg)
                2'd0: exp_rd = {24'h0, ref_cmd[ch]};
                2'd1: exp_rd = {24'h0, cfg_mode};
                2'd2: exp_rd = {24'h0, ref_stat[ch][7:1], act[ch]};
                default: exp_rd = {24'h0, cfg_tim[ch]};
            endcase
            chk(fw ? "R11 fwd read" : (s != 0 ? "R2 wide read" : "R3 R7 R9 R10 byte read"),
                acc_rdata, exp_rd);
        end
        chk("R8 start/dir", {28'h0, dma_start, dma_dir},
            {28'h0, ref_cmd[1][0], ref_cmd[0][0], ref_cmd[1][3], ref_cmd[0][3]});
        chk("R11 fwd_valid", {31'h0, fwd_valid}, {31'h0, fw});
        if (fw) begin
            chk("R11 fwd fields", {26'h0, fwd_write, fwd_chan, fwd_off, fwd_size},
                {26'h0, w, a[3], a[1:0], s});
            chk("R11 fwd wdata", fwd_wdata, wd);
        end
        chk("R2 R9 R12 mode strobe", {31'h0, cfg_mode_wr}, {31'h0, byte_reg && w && rg == 2'd1});
        if (byte_reg && w && rg == 2'd1)
            chk("R9 mode merge", {24'h0, cfg_mode_wdata},
                {24'h0, (cfg_mode & 8'hCF) | (wd[7:0] & 8'h30)});
        exp_tw = (byte_reg && w && rg == 2'd3) ? (2'b01 << ch) : 2'b00;
        chk("R10 timing strobe", {30'h0, cfg_tim_wr}, {30'h0, exp_tw});
        if (exp_tw != 0) chk("R10 timing data", {24'h0, cfg_tim_wdata}, {24'h0, wd[7:0]});
        @(posedge clk);
        if (byte_reg && w) begin
            case (rg)
                2'd0: ref_cmd[ch] = wd[7:0] & 8'h09;
                2'd1: cfg_mode = (cfg_mode & 8'hCF) | (wd[7:0] & 8'h30);
                2'd2: ref_stat[ch] = (wd[7:0] & 8'h60) | (ref_stat[ch] & ~wd[7:0] & 8'h06);
                default: cfg_tim[ch] = wd[7:0];
            endcase
        end
        for (int c = 0; c < 2; c++) begin
            if (err[c]) ref_stat[c][1] = 1'b1;
            if (irq[c]) ref_stat[c][2] = 1'b1;
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] act);
        cycle(1'b1, 1'b0, a, 2'd0, 32'h0, act, 2'b00, 2'b00);
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        cycle(1'b1, 1'b1, a, s, d, 2'b00, 2'b00, 2'b00);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        ref_cmd[0] = 0; ref_cmd[1] = 0; ref_stat[0] = 0; ref_stat[1] = 0;
        cfg_tim[0] = 8'h11; cfg_tim[1] = 8'h22;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of both channels
        rd(4'h0, 2'b00); rd(4'h8, 2'b00); rd(4'h2, 2'b00); rd(4'hA, 2'b00);
        // R7: active bit follows input
        rd(4'h2, 2'b01); rd(4'hA, 2'b10);
        wr(4'h2, 2'd0, 32'h01); rd(4'h2, 2'b00);
        // R8: command masking per channel
        wr(4'h0, 2'd0, 32'hFF); rd(4'h0, 2'b00); rd(4'h8, 2'b00);
        wr(4'h8, 2'd0, 32'h08); rd(4'h8, 2'b00);
        // R4: storage bits
        wr(4'h2, 2'd0, 32'hFF); rd(4'h2, 2'b00); rd(4'hA, 2'b00);
        // R6: events
        cycle(1'b0, 1'b0, 4'h0, 2'd0, 0, 2'b00, 2'b01, 2'b10);
        rd(4'h2, 2'b00); rd(4'hA, 2'b00);
        // R5: write one clears, zero keeps
        wr(4'h2, 2'd0, 32'h02); rd(4'h2, 2'b00);
        wr(4'hA, 2'd0, 32'h00); rd(4'hA, 2'b00);
        // R6: set beats clear in same cycle
        cycle(1'b1, 1'b1, 4'hA, 2'd0, 32'h04, 2'b00, 2'b00, 2'b10);
        rd(4'hA, 2'b00);
        // R9: mode alias
        cfg_mode = 8'hCC; rd(4'h1, 2'b00);
        wr(4'h1, 2'd0, 32'hFF); rd(4'h9, 2'b00);
        wr(4'h9, 2'd0, 32'h00); rd(4'h1, 2'b00);
        // R10: timing bytes
        rd(4'h3, 2'b00); rd(4'hB, 2'b00);
        wr(4'h3, 2'd0, 32'h5A); wr(4'hB, 2'd0, 32'hA5); rd(4'h3, 2'b00); rd(4'hB, 2'b00);
        // R2: wide accesses
        for (int s = 1; s < 4; s++) begin
            cycle(1'b1, 1'b0, 4'h0, 2'(s), 0, 2'b00, 2'b00, 2'b00);
            wr(4'h0, 2'(s), 32'h0);
            wr(4'h2, 2'(s), 32'hFFFF_FFFF);
            wr(4'h9, 2'(s), 32'hFF);
            wr(4'hB, 2'(s), 32'h00);
        end
        rd(4'h0, 2'b00); rd(4'h2, 2'b00); rd(4'h1, 2'b00); rd(4'hB, 2'b00);
        // R11: forwarding of address bytes
        wr(4'h4, 2'd2, 32'h1234_5678); rd(4'h5, 2'b00); wr(4'hE, 2'd1, 32'hCAFE);
        cycle(1'b1, 1'b0, 4'hF, 2'd3, 0, 2'b00, 2'b00, 2'b00);
        // R12 plus mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0] | r[1], r[2], r[7:4], (r[9:8] == 2'd3) ? r[11:10] : 2'd0,
                  {r[31:16], 8'h00, r[23:16]}, r[13:12], r[15:14] & {2{r[24]}},
                  r[27:26] & {2{r[25]}});
        end
        rd(4'h0, 2'b00); rd(4'h2, 2'b11); rd(4'hA, 2'b00);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule